// File: doc/BRIEF.md
# Sub-Register Aliased Register File

This block holds eight 32-bit general registers for an integer core. The register codes follow the same order the core uses when it saves every register on the stack: accumulator, counter, data, base, stack pointer, base pointer, source index, destination index. Each access to a register names a width. A full access covers all 32 bits. A half access covers the low 16 bits. A byte access covers one 8-bit slice. Only the first four registers have byte slices, and each of them has a low byte and a high byte.

There is one write port and two independent read ports. A narrow write replaces only its own slice and keeps the rest of the register. A read returns its slice aligned to bit 0. The bits above the slice are filled with zeros, or with copies of the slice's top bit when the port's sign-extend input is set. This matches what zero-extending and sign-extending moves need.

The write port has a second mode that exchanges two whole registers on a single clock edge, so no scratch register is needed. Reads see the state that the coming clock edge will store. A value being written, or a pair being swapped, therefore reaches the read ports in the same cycle.

Top module: `regfile_alias`

## Requirements
- R1: Register codes 0 to 7 select the accumulator, counter, data, base, stack pointer, base pointer, source index and destination index, in that order. Width code 2'b10, and also 2'b11, accesses all 32 bits of the coded register.
- R2: Width code 2'b01 accesses bits 15:0 of the coded register, for any of the eight codes.
- R3: Width code 2'b00 is a byte access. Codes 0 to 3 select bits 7:0 of registers 0 to 3. Codes 4 to 7 select bits 15:8 of registers 0 to 3. A byte access never reaches registers 4 to 7.
- R4: A half or byte write leaves every bit of the target register outside its slice unchanged.
- R5: With the sign-extend input low, a read fills the bits above the slice with zeros.
- R6: With the sign-extend input high, a read fills the bits above the slice with copies of the slice's top bit. For example, byte 0xE8 reads as 0xFFFFFFE8 and half 0x8001 reads as 0xFFFF8001. The input has no effect on a full read.
- R7: A read in the same cycle as a write or a swap returns the value that the coming clock edge stores.
- R8: A swap exchanges the full 32-bit values of its two registers on one clock edge. A swap of a register with itself changes nothing.
- R9: When the swap and write enables are both high, the swap is performed and the write is ignored.
- R10: The asynchronous reset clears all eight registers to zero.
- R11: With both write and swap enables low, no register changes.
- R12: The two read ports decode their register code, width and extension independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 3 | Write register code |
| wr_width_i | input | 2 | Write width code |
| wr_data_i | input | 32 | Write data, slice taken from the low bits |
| swap_en_i | input | 1 | Exchange two registers |
| swap_a_i | input | 3 | First register of the exchange |
| swap_b_i | input | 3 | Second register of the exchange |
| rd0_addr_i | input | 3 | Read port 0 register code |
| rd0_width_i | input | 2 | Read port 0 width code |
| rd0_sext_i | input | 1 | Read port 0 sign-extend select |
| rd0_data_o | output | 32 | Read port 0 data |
| rd1_addr_i | input | 3 | Read port 1 register code |
| rd1_width_i | input | 2 | Read port 1 width code |
| rd1_sext_i | input | 1 | Read port 1 sign-extend select |
| rd1_data_o | output | 32 | Read port 1 data |

## Verification
Read data is combinational and is due in the same cycle as its address, width and extension inputs, including any write or swap presented in that cycle. Stored state changes only at the next rising edge. The bench drives all inputs just after a falling edge and samples both read ports one nanosecond later. Its reference model steps forward only after the following rising edge, so each check compares against the state that edge commits, and each committed write is checked again by later reads.

// File: rtl/regfile_alias_pkg.sv
package regfile_alias_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned HALF_W    = 16;
  localparam int unsigned NUM_REGS  = 8;
  localparam int unsigned NUM_RD    = 2;
  localparam int unsigned NUM_LANES = DATA_W / BYTE_W;
  localparam int unsigned HALF_LANES = HALF_W / BYTE_W;
  localparam int unsigned REG_AW    = $clog2(NUM_REGS);
  localparam int unsigned LANE_AW   = $clog2(NUM_LANES);
  localparam int unsigned BIT_AW    = $clog2(DATA_W);

  typedef enum logic [1:0] {
    ACC_BYTE     = 2'b00,
    ACC_HALF     = 2'b01,
    ACC_FULL     = 2'b10,
    ACC_FULL_ALT = 2'b11
  } acc_width_e;

  typedef struct packed {
    logic [REG_AW-1:0]    idx;
    logic [NUM_LANES-1:0] lanes;
    logic [LANE_AW-1:0]   shift;
  } slice_t;
endpackage

// File: rtl/regfile_alias_dec.sv
module regfile_alias_dec
  import regfile_alias_pkg::*;
(
  input  logic [REG_AW-1:0] code_i,
  input  logic [1:0]        width_i,
  output slice_t            slice_o
);
  always_comb begin
    slice_o.idx   = code_i;
    slice_o.lanes = '1;
    slice_o.shift = '0;
    case (acc_width_e'(width_i))
      ACC_BYTE: begin
        // upper half of code space picks the high byte of the lower registers
        slice_o.idx   = {1'b0, code_i[REG_AW-2:0]};
        slice_o.shift = LANE_AW'(code_i[REG_AW-1]);
        slice_o.lanes = NUM_LANES'(1) << slice_o.shift;
      end
      ACC_HALF: slice_o.lanes = NUM_LANES'((1 << HALF_LANES) - 1);
      default: ;
    endcase
  end
endmodule

// File: rtl/regfile_alias_update.sv
module regfile_alias_update
  import regfile_alias_pkg::*;
(
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic                            wr_en_i,
  input  slice_t                          wr_slice_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  input  logic                            swap_en_i,
  input  logic [REG_AW-1:0]               swap_a_i,
  input  logic [REG_AW-1:0]               swap_b_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] next_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0]  nxt;
    logic [LANE_AW-1:0] src;

    always_comb begin
      nxt = regs_i[g];
      src = '0;
      if (swap_en_i) begin
        if (swap_a_i == REG_AW'(g))      nxt = regs_i[swap_b_i];
        else if (swap_b_i == REG_AW'(g)) nxt = regs_i[swap_a_i];
      end else if (wr_en_i && (wr_slice_i.idx == REG_AW'(g))) begin
        for (int l = 0; l < NUM_LANES; l++) begin
          if (wr_slice_i.lanes[l]) begin
            src = LANE_AW'(l) - wr_slice_i.shift;
            nxt[l*BYTE_W +: BYTE_W] = wr_data_i[src*BYTE_W +: BYTE_W];
          end
        end
      end
    end

    assign next_o[g] = nxt;
  end
endmodule

// File: rtl/regfile_alias_rdport.sv
module regfile_alias_rdport
  import regfile_alias_pkg::*;
(
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  slice_t                          slice_i,
  input  logic                            sext_i,
  output logic [DATA_W-1:0]               data_o
);
  logic [DATA_W-1:0] word, aligned;
  logic [BIT_AW-1:0] msb;
  logic              fill;
  int                nbits;

  always_comb begin
    word    = regs_i[slice_i.idx];
    aligned = word >> (slice_i.shift * BYTE_W);
    nbits   = $countones(slice_i.lanes) * BYTE_W;
    msb     = BIT_AW'(nbits - 1);
    fill    = sext_i & aligned[msb];
    for (int k = 0; k < DATA_W; k++) begin
      data_o[k] = (k < nbits) ? aligned[k] : fill;
    end
  end
endmodule

// File: rtl/regfile_alias.sv
module regfile_alias
  import regfile_alias_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_AW-1:0]   wr_addr_i,
  input  logic [1:0]          wr_width_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                swap_en_i,
  input  logic [REG_AW-1:0]   swap_a_i,
  input  logic [REG_AW-1:0]   swap_b_i,
  input  logic [REG_AW-1:0]   rd0_addr_i,
  input  logic [1:0]          rd0_width_i,
  input  logic                rd0_sext_i,
  output logic [DATA_W-1:0]   rd0_data_o,
  input  logic [REG_AW-1:0]   rd1_addr_i,
  input  logic [1:0]          rd1_width_i,
  input  logic                rd1_sext_i,
  output logic [DATA_W-1:0]   rd1_data_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q, regs_d;
  slice_t                          wr_slice;

  logic [REG_AW-1:0] rd_addr [NUM_RD];
  logic [1:0]        rd_width[NUM_RD];
  logic              rd_sext [NUM_RD];
  logic [DATA_W-1:0] rd_data [NUM_RD];

  assign rd_addr[0]  = rd0_addr_i;
  assign rd_width[0] = rd0_width_i;
  assign rd_sext[0]  = rd0_sext_i;
  assign rd_addr[1]  = rd1_addr_i;
  assign rd_width[1] = rd1_width_i;
  assign rd_sext[1]  = rd1_sext_i;
  assign rd0_data_o  = rd_data[0];
  assign rd1_data_o  = rd_data[1];

  regfile_alias_dec u_wr_dec (
    .code_i  (wr_addr_i),
    .width_i (wr_width_i),
    .slice_o (wr_slice)
  );

  regfile_alias_update u_update (
    .regs_i     (regs_q),
    .wr_en_i    (wr_en_i),
    .wr_slice_i (wr_slice),
    .wr_data_i  (wr_data_i),
    .swap_en_i  (swap_en_i),
    .swap_a_i   (swap_a_i),
    .swap_b_i   (swap_b_i),
    .next_o     (regs_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else         regs_q <= regs_d;
  end

  // read ports look at regs_d: same-cycle bypass of write and swap
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    slice_t rd_slice;

    regfile_alias_dec u_rd_dec (
      .code_i  (rd_addr[p]),
      .width_i (rd_width[p]),
      .slice_o (rd_slice)
    );

    regfile_alias_rdport u_rdport (
      .regs_i  (regs_d),
      .slice_i (rd_slice),
      .sext_i  (rd_sext[p]),
      .data_o  (rd_data[p])
    );
  end
endmodule

// File: rtl/regfile_alias_chk.sv
module regfile_alias_chk
  import regfile_alias_pkg::*;
(
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_en_i,
  input logic [REG_AW-1:0]               wr_addr_i,
  input logic [1:0]                      wr_width_i,
  input logic [DATA_W-1:0]               wr_data_i,
  input logic                            swap_en_i,
  input logic [REG_AW-1:0]               swap_a_i,
  input logic [REG_AW-1:0]               swap_b_i,
  input logic [REG_AW-1:0]               rd0_addr_i,
  input logic [1:0]                      rd0_width_i,
  input logic                            rd0_sext_i,
  input logic [DATA_W-1:0]               rd0_data_o,
  input logic [REG_AW-1:0]               rd1_addr_i,
  input logic [1:0]                      rd1_width_i,
  input logic                            rd1_sext_i,
  input logic [DATA_W-1:0]               rd1_data_o,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
  a_r2_half_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !swap_en_i && wr_width_i == 2'b01)
    |=> regs_q[$past(wr_addr_i)][15:0] == $past(wr_data_i[15:0]));

  a_r4_half_keeps_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !swap_en_i && wr_width_i == 2'b01)
    |=> regs_q[$past(wr_addr_i)][31:16] == $past(regs_q[wr_addr_i][31:16]));

  a_r3_high_byte_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !swap_en_i && wr_width_i == 2'b00 && wr_addr_i[2])
    |=> regs_q[$past(wr_addr_i[1:0])][15:8] == $past(wr_data_i[7:0]));

  a_r3_byte_spares_upper_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !swap_en_i && wr_width_i == 2'b00)
    |=> regs_q[7:4] == $past(regs_q[7:4]));

  a_r8_swap_exchange: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_en_i |=> regs_q[$past(swap_a_i)] == $past(regs_q[swap_b_i]));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !swap_en_i) |=> $stable(regs_q));

  a_r5_zero_ext_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd0_sext_i && rd0_width_i == 2'b00) |-> rd0_data_o[31:8] == '0);

  a_r5_zero_ext_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd1_sext_i && rd1_width_i == 2'b01) |-> rd1_data_o[31:16] == '0);

  a_r6_sign_ext_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd0_sext_i && rd0_width_i == 2'b00) |-> rd0_data_o[31:8] == {24{rd0_data_o[7]}});

  a_r6_sign_ext_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd1_sext_i && rd1_width_i == 2'b01) |-> rd1_data_o[31:16] == {16{rd1_data_o[15]}});
endmodule

bind regfile_alias regfile_alias_chk u_chk (.*);

// File: tb/regfile_alias_test.sv
module regfile_alias_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, swap_en = 1'b0;
  logic [2:0]  wr_addr = '0, swap_a = '0, swap_b = '0;
  logic [1:0]  wr_width = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd0_addr = '0, rd1_addr = '0;
  logic [1:0]  rd0_width = 2'b10, rd1_width = 2'b10;
  logic        rd0_sext = 1'b0, rd1_sext = 1'b0;
  logic [31:0] rd0_data, rd1_data;

  logic [7:0][31:0] m = '0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_alias uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_width_i(wr_width), .wr_data_i(wr_data),
    .swap_en_i(swap_en), .swap_a_i(swap_a), .swap_b_i(swap_b),
    .rd0_addr_i(rd0_addr), .rd0_width_i(rd0_width), .rd0_sext_i(rd0_sext), .rd0_data_o(rd0_data),
    .rd1_addr_i(rd1_addr), .rd1_width_i(rd1_width), .rd1_sext_i(rd1_sext), .rd1_data_o(rd1_data)
  );

  function automatic logic [31:0] ref_read(input logic [7:0][31:0] mm, input logic [2:0] a,
                                           input logic [1:0] w, input logic s);
    logic [31:0] v;
    int n;
    if (w == 2'b00) begin
      v = a[2] ? {24'b0, mm[a[1:0]][15:8]} : {24'b0, mm[a[1:0]][7:0]};
      n = 8;
    end else if (w == 2'b01) begin
      v = {16'b0, mm[a][15:0]};
      n = 16;
    end else begin
      v = mm[a];
      n = 32;
    end
    if (s && n < 32 && v[n-1]) v = v | ~((32'h1 << n) - 32'h1);
    return v;
  endfunction

  function automatic logic [7:0][31:0] ref_next(input logic [7:0][31:0] mm, input logic we,
      input logic [2:0] wa, input logic [1:0] ww, input logic [31:0] wd,
      input logic se, input logic [2:0] sa, input logic [2:0] sb);
    logic [31:0] t;
    if (se) begin
      t = mm[sa]; mm[sa] = mm[sb]; mm[sb] = t;
    end else if (we) begin
      if (ww == 2'b00) begin
        if (wa[2]) mm[wa[1:0]][15:8] = wd[7:0];
        else       mm[wa[1:0]][7:0]  = wd[7:0];
      end else if (ww == 2'b01) mm[wa][15:0] = wd[15:0];
      else mm[wa] = wd;
    end
    return mm;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag, input string port);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, port, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] wa, input logic [1:0] ww, input logic [31:0] wd,
                      input logic se, input logic [2:0] sa, input logic [2:0] sb,
                      input logic [2:0] a0, input logic [1:0] w0, input logic s0,
                      input logic [2:0] a1, input logic [1:0] w1, input logic s1, input string tag);
    logic [7:0][31:0] mn;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_width = ww; wr_data = wd;
    swap_en = se; swap_a = sa; swap_b = sb;
    rd0_addr = a0; rd0_width = w0; rd0_sext = s0;
    rd1_addr = a1; rd1_width = w1; rd1_sext = s1;
    #1;
    mn = ref_next(m, we, wa, ww, wd, se, sa, sb);
    check(rd0_data, ref_read(mn, a0, w0, s0), tag, "port0");
    check(rd1_data, ref_read(mn, a1, w1, s1), tag, "port1 R12");
    @(posedge clk);
    m = mn;
  endtask

  task automatic sweep_reads(input string zero_tag);
    for (int c = 0; c < 64; c++) begin
      logic [5:0] cc, dd;
      string t;
      cc = 6'(c);
      dd = 6'(63 - c);
      if (zero_tag.len() != 0) t = zero_tag;
      else if (cc[5]) t = "R6";
      else if (cc[4:3] == 2'b00) t = "R5 R3";
      else if (cc[4:3] == 2'b01) t = "R5 R2";
      else t = "R1";
      step(1'b0, 3'd0, 2'b10, 32'h0, 1'b0, 3'd0, 3'd0,
           cc[2:0], cc[4:3], cc[5], dd[2:0], dd[4:3], dd[5], t);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0; swap_en = 1'b0;
    repeat (2) @(posedge clk);
    m = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10: everything reads zero after reset
    sweep_reads("R10");

    // R1 R7: full writes, checked in the same cycle through the bypass
    for (int i = 0; i < 8; i++) begin
      logic [31:0] d;
      d = 32'h8765_43A1 + 32'h1111_1111 * 32'(i);
      step(1'b1, 3'(i), 2'b10, d, 1'b0, 3'd0, 3'd0,
           3'(i), 2'b10, 1'b0, 3'(i), 2'b00, 1'b1, "R7 R1");
    end
    // R1: reserved width code acts as full
    step(1'b1, 3'd5, 2'b11, 32'hCAFE_F00D, 1'b0, 3'd0, 3'd0,
         3'd5, 2'b11, 1'b1, 3'd5, 2'b10, 1'b0, "R1");

    sweep_reads("");

    // R2 R3 R4: narrow writes, full read of the target alongside the slice read
    for (int k = 0; k < 3; k++) begin
      for (int a = 0; a < 8; a++) begin
        for (int w = 0; w < 2; w++) begin
          logic [31:0] d;
          logic [2:0]  full_a;
          d = 32'h9E37_79B9 * 32'(k * 16 + a * 2 + w + 1);
          full_a = (w == 0) ? {1'b0, 2'(a)} : 3'(a);
          step(1'b1, 3'(a), 2'(w), d, 1'b0, 3'd0, 3'd0,
               full_a, 2'b10, 1'b0, 3'(a), 2'(w), k[0], (w == 0) ? "R3 R4" : "R2 R4");
        end
        // R3: upper registers untouched by byte codes 4..7
        step(1'b0, 3'd0, 2'b10, 32'h0, 1'b0, 3'd0, 3'd0,
             3'd4 + 3'(a[1:0]), 2'b10, 1'b0, 3'd7, 2'b01, 1'b0, "R3 R4");
      end
      sweep_reads("");
    end

    // R6: fixed sign examples
    step(1'b1, 3'd1, 2'b00, 32'h0000_00E8, 1'b0, 3'd0, 3'd0,
         3'd1, 2'b00, 1'b1, 3'd1, 2'b00, 1'b0, "R6 R5");
    step(1'b1, 3'd6, 2'b01, 32'h1234_8001, 1'b0, 3'd0, 3'd0,
         3'd6, 2'b01, 1'b1, 3'd6, 2'b10, 1'b1, "R6");

    // R8: swap visible in the same cycle and afterwards
    step(1'b0, 3'd0, 2'b10, 32'h0, 1'b1, 3'd1, 3'd6,
         3'd1, 2'b10, 1'b0, 3'd6, 2'b10, 1'b0, "R8 R7");
    step(1'b0, 3'd0, 2'b10, 32'h0, 1'b0, 3'd0, 3'd0,
         3'd6, 2'b10, 1'b0, 3'd1, 2'b10, 1'b0, "R8");
    step(1'b0, 3'd0, 2'b10, 32'h0, 1'b1, 3'd3, 3'd3,
         3'd3, 2'b10, 1'b0, 3'd7, 2'b10, 1'b0, "R8");
    step(1'b0, 3'd0, 2'b10, 32'h0, 1'b1, 3'd0, 3'd7,
         3'd0, 2'b10, 1'b0, 3'd7, 2'b10, 1'b0, "R8");

    // R9: write ignored while a swap runs
    step(1'b1, 3'd2, 2'b10, 32'hDEAD_BEEF, 1'b1, 3'd4, 3'd5,
         3'd2, 2'b10, 1'b0, 3'd4, 2'b10, 1'b0, "R9");
    step(1'b0, 3'd0, 2'b10, 32'h0, 1'b0, 3'd0, 3'd0,
         3'd2, 2'b10, 1'b0, 3'd5, 2'b10, 1'b0, "R9");

    // R11: idle cycles hold every register
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 3'(i), 2'b10, 32'hFFFF_FFFF, 1'b0, 3'd0, 3'd0,
           3'(i), 2'b10, 1'b0, 3'(7 - i), 2'b10, 1'b0, "R11");
    end
    sweep_reads("");

    // R10: mid-run reset clears all
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 3'd0, 2'b10, 32'h0, 1'b0, 3'd0, 3'd0,
           3'(i), 2'b10, 1'b0, 3'(i), 2'b01, 1'b1, "R10");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule